// File: doc/BRIEF.md
# Dual DAC Register Front End

This block is the digital register front end for a pair of 12-bit DAC channels. It sits on a byte-wide register bus with address, write data, write strobe, read strobe and read data. It holds one control register and, for each channel, a low data byte and a high data nibble. It decides when each channel's output code latch is loaded. It then drives each channel's 12-bit code, its range-select bit and its power-enable bit towards the analog side.

A channel's latch loads in one of two ways. The first is direct: a write to the channel's low byte while the control register's synchronisation bit is set. The second is simultaneous: both channels load together on the cycle after the synchronisation bit is raised. A narrow mode takes an 8-bit code from the low byte alone. Per-channel clear and power-down bits hold the presented code at zero without disturbing stored data, so the previous output returns without any rewrite.

Top module: `dac_regfront`

## Requirements
- R1: After reset the control register reads 0x04 and all four data registers read 0x00. Both codes are zero, and `pwr_en` and `rng_sel` are both 2'b00.
- R2: With `bus_re` high, `bus_rdata` returns the stored value of the addressed register combinationally. Control is at 0xFD; channel 0 low/high are at 0xF9/0xFA; channel 1 low/high are at 0xFB/0xFC. The upper nibble of a high register reads as zero. An unmapped address reads 0x00.
- R3: With control bit 2 (sync) at 1 and bit 7 (narrow) at 0, a low-byte write loads the channel latch at that clock edge with {high[3:0], low}. A high-byte write alone leaves the latch unchanged.
- R4: While sync is 0, data register writes do not change either latch.
- R5: A control write that takes sync from 0 to 1 loads both latches from their data registers at the following clock edge.
- R6: A control write with sync set, made while sync is already 1, does not reload either latch.
- R7: With bit 7 at 1, the code is {low, 4'b0000}, and high-byte writes do not affect the code. The same sync rules apply.
- R8: Clear bits are bit 3 (ch0) and bit 4 (ch1). A clear bit at 0 forces that channel's code to zero. Setting it back to 1 restores the latched code.
- R9: Power bits are bit 0 (ch0) and bit 1 (ch1) and drive `pwr_en[x]`. A power bit at 0 also forces the code to zero. Setting it back to 1 restores the latched code.
- R10: Range bits are bit 5 (ch0) and bit 6 (ch1) and drive `rng_sel[x]` (1 selects the supply range, 0 the reference range).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 8 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_we | input | 1 | Write strobe, sampled at the rising edge |
| bus_re | input | 1 | Read strobe |
| bus_rdata | output | 8 | Read data, zero when not reading a mapped register |
| code0 | output | 12 | Channel 0 output code |
| code1 | output | 12 | Channel 1 output code |
| rng_sel | output | 2 | Per-channel range select |
| pwr_en | output | 2 | Per-channel power enable |

## Verification
Read data is combinational: it is due in the same cycle that the strobe and address are held. A direct low-byte load appears after the edge that samples the write. A sync-rise load appears one edge later, because the rise is first captured in a pulse register. Control effects such as clear, power and range appear after the control write edge. The driver holds every write for one edge and then idles for one more edge before it queues expectations, so even the later simultaneous load has settled. The monitor compares queued items 5 ns after a rising edge, while read strobes are still held and no write is in flight.

// File: rtl/dac_regfront_pkg.sv
package dac_regfront_pkg;
   // control register bit positions (decoded by the channel logic)
   localparam int CB_PD0   = 0;
   localparam int CB_SYNC  = 2;
   localparam int CB_CLR0  = 3;
   localparam int CB_RNG0  = 5;
   localparam int CB_NARROW = 7;
   localparam int NCH      = 2;
   localparam logic [7:0] CTRL_RESET = 8'h04;

   function automatic int pd_bit(input int ch);
      return CB_PD0 + ch;
   endfunction
   function automatic int clr_bit(input int ch);
      return CB_CLR0 + ch;
   endfunction
   function automatic int rng_bit(input int ch);
      return CB_RNG0 + ch;
   endfunction
endpackage

// File: rtl/dacrf_ctrl.sv
module dacrf_ctrl
   import dac_regfront_pkg::*;
#(
   parameter int ADDR_W    = 8,
   parameter int BYTE_W    = 8,
   parameter int CTRL_ADDR = 'hFD
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] addr,
   input  logic [BYTE_W-1:0] wr_data,
   output logic [BYTE_W-1:0] ctrl_q,
   output logic              sync_load,
   output logic              rd_hit
);
   localparam logic [ADDR_W-1:0] CA = ADDR_W'(CTRL_ADDR);

   logic ctrl_wr;
   logic sync_rise;

   assign ctrl_wr   = wr_en && (addr == CA);
   assign sync_rise = ctrl_wr && wr_data[CB_SYNC] && !ctrl_q[CB_SYNC];
   assign rd_hit    = (addr == CA);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q    <= BYTE_W'(CTRL_RESET);
         sync_load <= 1'b0;
      end else begin
         sync_load <= sync_rise;
         if (ctrl_wr) ctrl_q <= wr_data;
      end
   end
endmodule

// File: rtl/dacrf_chan.sv
module dacrf_chan #(
   parameter int ADDR_W  = 8,
   parameter int BYTE_W  = 8,
   parameter int CODE_W  = 12,
   parameter int LO_ADDR = 'hF9,
   parameter int HI_ADDR = 'hFA
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      wr_en,
   input  logic [ADDR_W-1:0]         addr,
   input  logic [BYTE_W-1:0]         wr_data,
   input  logic                      direct_en,
   input  logic                      narrow,
   input  logic                      sync_load,
   input  logic                      out_en,
   output logic [BYTE_W-1:0]         lo_q,
   output logic [CODE_W-BYTE_W-1:0]  hi_q,
   output logic [CODE_W-1:0]         lat_q,
   output logic [CODE_W-1:0]         code_o,
   output logic                      rd_hit,
   output logic [BYTE_W-1:0]         rd_val
);
   localparam int HI_W  = CODE_W - BYTE_W;
   localparam int PAD_R = BYTE_W - HI_W;
   localparam logic [ADDR_W-1:0] LA = ADDR_W'(LO_ADDR);
   localparam logic [ADDR_W-1:0] HA = ADDR_W'(HI_ADDR);

   logic             lo_wr, hi_wr;
   logic [CODE_W-1:0] direct_code, stored_code;

   assign lo_wr = wr_en && (addr == LA);
   assign hi_wr = wr_en && (addr == HA);

   assign direct_code = narrow ? {wr_data, {HI_W{1'b0}}} : {hi_q, wr_data};
   assign stored_code = narrow ? {lo_q, {HI_W{1'b0}}}    : {hi_q, lo_q};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lo_q  <= '0;
         hi_q  <= '0;
         lat_q <= '0;
      end else begin
         if (lo_wr) lo_q <= wr_data;
         if (hi_wr) hi_q <= wr_data[HI_W-1:0];
         // a direct load carries newer data than a pending simultaneous load
         if (lo_wr && direct_en) lat_q <= direct_code;
         else if (sync_load)     lat_q <= stored_code;
      end
   end

   assign code_o = out_en ? lat_q : '0;

   always_comb begin
      rd_hit = (addr == LA) || (addr == HA);
      if (addr == LA)      rd_val = lo_q;
      else if (addr == HA) rd_val = {{PAD_R{1'b0}}, hi_q};
      else                 rd_val = '0;
   end
endmodule

// File: rtl/dac_regfront.sv
module dac_regfront
   import dac_regfront_pkg::*;
#(
   parameter int ADDR_W    = 8,
   parameter int BYTE_W    = 8,
   parameter int CODE_W    = 12,
   parameter int DATA_BASE = 'hF9,
   parameter int CTRL_ADDR = 'hFD
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [BYTE_W-1:0] bus_wdata,
   input  logic              bus_we,
   input  logic              bus_re,
   output logic [BYTE_W-1:0] bus_rdata,
   output logic [CODE_W-1:0] code0,
   output logic [CODE_W-1:0] code1,
   output logic [NCH-1:0]    rng_sel,
   output logic [NCH-1:0]    pwr_en
);
   localparam int HI_W = CODE_W - BYTE_W;

   if (CODE_W <= BYTE_W || HI_W > BYTE_W) begin : g_bad_width
      $error("dac_regfront: CODE_W must lie in (BYTE_W, 2*BYTE_W]");
   end
   if (BYTE_W <= CB_NARROW) begin : g_bad_byte
      $error("dac_regfront: BYTE_W too narrow for the control layout");
   end

   logic [BYTE_W-1:0] ctrl_q;
   logic              sync_load;
   logic              ctrl_hit;
   logic [BYTE_W-1:0] lo_q     [NCH];
   logic [HI_W-1:0]   hi_q     [NCH];
   logic [CODE_W-1:0] lat_code [NCH];
   logic [CODE_W-1:0] ch_code  [NCH];
   logic [NCH-1:0]    ch_hit;
   logic [BYTE_W-1:0] ch_rd    [NCH];

   dacrf_ctrl #(
      .ADDR_W(ADDR_W), .BYTE_W(BYTE_W), .CTRL_ADDR(CTRL_ADDR)
   ) u_ctrl (
      .clk(clk), .rst_n(rst_n), .wr_en(bus_we), .addr(bus_addr),
      .wr_data(bus_wdata), .ctrl_q(ctrl_q), .sync_load(sync_load),
      .rd_hit(ctrl_hit)
   );

   for (genvar c = 0; c < NCH; c++) begin : g_ch
      dacrf_chan #(
         .ADDR_W(ADDR_W), .BYTE_W(BYTE_W), .CODE_W(CODE_W),
         .LO_ADDR(DATA_BASE + 2*c), .HI_ADDR(DATA_BASE + 2*c + 1)
      ) u_chan (
         .clk(clk), .rst_n(rst_n), .wr_en(bus_we), .addr(bus_addr),
         .wr_data(bus_wdata),
         .direct_en(ctrl_q[CB_SYNC]),
         .narrow(ctrl_q[CB_NARROW]),
         .sync_load(sync_load),
         .out_en(ctrl_q[clr_bit(c)] && ctrl_q[pd_bit(c)]),
         .lo_q(lo_q[c]), .hi_q(hi_q[c]), .lat_q(lat_code[c]),
         .code_o(ch_code[c]), .rd_hit(ch_hit[c]), .rd_val(ch_rd[c])
      );
      assign rng_sel[c] = ctrl_q[rng_bit(c)];
      assign pwr_en[c]  = ctrl_q[pd_bit(c)];
   end

   always_comb begin
      bus_rdata = '0;
      if (bus_re) begin
         if (ctrl_hit) bus_rdata = ctrl_q;
         for (int c = 0; c < NCH; c++)
            if (ch_hit[c]) bus_rdata = ch_rd[c];
      end
   end

   assign code0 = ch_code[0];
   assign code1 = ch_code[1];
endmodule

// File: rtl/dac_regfront_chk.sv
module dac_regfront_chk
   import dac_regfront_pkg::*;
#(
   parameter int ADDR_W    = 8,
   parameter int BYTE_W    = 8,
   parameter int CODE_W    = 12,
   parameter int DATA_BASE = 'hF9,
   parameter int CTRL_ADDR = 'hFD
) (
   input logic                     clk,
   input logic                     rst_n,
   input logic                     bus_we,
   input logic [ADDR_W-1:0]        bus_addr,
   input logic [BYTE_W-1:0]        bus_wdata,
   input logic [BYTE_W-1:0]        ctrl_q,
   input logic [BYTE_W-1:0]        lo0,
   input logic [CODE_W-BYTE_W-1:0] hi0,
   input logic [CODE_W-1:0]        lat0,
   input logic [CODE_W-1:0]        lat1,
   input logic [CODE_W-1:0]        code0,
   input logic [CODE_W-1:0]        code1,
   input logic [NCH-1:0]           pwr_en
);
   localparam int HI_W = CODE_W - BYTE_W;
   localparam logic [ADDR_W-1:0] LO0 = ADDR_W'(DATA_BASE);
   localparam logic [ADDR_W-1:0] CA  = ADDR_W'(CTRL_ADDR);

   logic              lo0_wr, sync_arm;
   logic [CODE_W-1:0] exp0;
   assign lo0_wr   = bus_we && bus_addr == LO0;
   assign sync_arm = bus_we && bus_addr == CA && bus_wdata[CB_SYNC] && !ctrl_q[CB_SYNC];
   assign exp0     = ctrl_q[CB_NARROW] ? {lo0, {HI_W{1'b0}}} : {hi0, lo0};

   // R3
   direct_wide_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (lo0_wr && ctrl_q[CB_SYNC] && !ctrl_q[CB_NARROW])
      |=> lat0 == {$past(hi0), $past(bus_wdata)});

   // R7
   direct_narrow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (lo0_wr && ctrl_q[CB_SYNC] && ctrl_q[CB_NARROW])
      |=> lat0 == {$past(bus_wdata), {HI_W{1'b0}}});

   // R4
   hold_nosync_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(!ctrl_q[CB_SYNC]) && !ctrl_q[CB_SYNC]) |-> ($stable(lat0) && $stable(lat1)));

   // R5
   sync_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      sync_arm ##1 !bus_we |=> lat0 == $past(exp0));

   // R8
   clear_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !ctrl_q[clr_bit(0)] |-> code0 == '0);

   // R9
   power_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !ctrl_q[pd_bit(1)] |-> (code1 == '0 && !pwr_en[1]));
endmodule

bind dac_regfront dac_regfront_chk #(
   .ADDR_W(ADDR_W), .BYTE_W(BYTE_W), .CODE_W(CODE_W),
   .DATA_BASE(DATA_BASE), .CTRL_ADDR(CTRL_ADDR)
) u_chk (
   .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
   .bus_wdata(bus_wdata), .ctrl_q(ctrl_q), .lo0(lo_q[0]), .hi0(hi_q[0]),
   .lat0(lat_code[0]), .lat1(lat_code[1]), .code0(code0), .code1(code1),
   .pwr_en(pwr_en)
);

// File: tb/dac_regfront_tb.sv
module dac_regfront_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [7:0]  bus_addr = '0;
   logic [7:0]  bus_wdata = '0;
   logic        bus_we = 1'b0;
   logic        bus_re = 1'b0;
   logic [7:0]  bus_rdata;
   logic [11:0] code0, code1;
   logic [1:0]  rng_sel, pwr_en;

   always #10 clk = ~clk;

   dac_regfront u_dut (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
      .bus_we(bus_we), .bus_re(bus_re), .bus_rdata(bus_rdata),
      .code0(code0), .code1(code1), .rng_sel(rng_sel), .pwr_en(pwr_en)
   );

   typedef struct {
      string       req;
      int          sel;   // 0 rdata, 1 code0, 2 code1, 3 pwr_en, 4 rng_sel
      logic [11:0] exp;
   } item_t;

   item_t sb_q[$];
   int checks = 0;
   int errors = 0;
   bit done = 0;

   // reference state, built from the requirements
   logic [7:0]  m_ctrl = 8'h04;
   logic [7:0]  m_lo [2] = '{8'h00, 8'h00};
   logic [3:0]  m_hi [2] = '{4'h0, 4'h0};
   logic [11:0] m_lat [2] = '{12'h000, 12'h000};

   function automatic logic [11:0] m_code(input int ch);
      if (m_ctrl[3+ch] && m_ctrl[ch]) return m_lat[ch];
      return 12'h000;
   endfunction

   task automatic expect_item(input string req, input int sel, input logic [11:0] exp);
      item_t it;
      it.req = req; it.sel = sel; it.exp = exp;
      sb_q.push_back(it);
   endtask

   task automatic expect_outputs(input string req);
      expect_item(req, 1, m_code(0));
      expect_item(req, 2, m_code(1));
      expect_item(req, 3, {10'd0, m_ctrl[1:0]});
      expect_item(req, 4, {10'd0, m_ctrl[6:5]});
   endtask

   // write held across one edge, then one idle edge so any sync load settles
   task automatic bus_write(input logic [7:0] a, input logic [7:0] d);
      @(negedge clk);
      bus_addr = a; bus_wdata = d; bus_we = 1'b1;
      @(negedge clk);
      bus_we = 1'b0;
      @(negedge clk);
      if (a == 8'hFD) begin
         logic rise;
         rise = d[2] && !m_ctrl[2];
         m_ctrl = d;
         if (rise)
            for (int c = 0; c < 2; c++)
               m_lat[c] = m_ctrl[7] ? {m_lo[c], 4'h0} : {m_hi[c], m_lo[c]};
      end else if (a == 8'hF9 || a == 8'hFB) begin
         int c;
         c = (a == 8'hF9) ? 0 : 1;
         m_lo[c] = d;
         if (m_ctrl[2]) m_lat[c] = m_ctrl[7] ? {d, 4'h0} : {m_hi[c], d};
      end else if (a == 8'hFA || a == 8'hFC) begin
         m_hi[(a == 8'hFA) ? 0 : 1] = d[3:0];
      end
   endtask

   task automatic bus_read(input string req, input logic [7:0] a, input logic [7:0] exp);
      @(negedge clk);
      bus_addr = a; bus_re = 1'b1;
      expect_item(req, 0, {4'h0, exp});
      @(negedge clk);
      bus_re = 1'b0;
   endtask

   // monitor: compares queued items 5 ns after each rising edge
   initial begin
      forever begin
         @(posedge clk);
         #5;
         while (sb_q.size() > 0) begin
            item_t it;
            logic [11:0] act;
            it = sb_q.pop_front();
            case (it.sel)
               0: act = {4'h0, bus_rdata};
               1: act = code0;
               2: act = code1;
               3: act = {10'd0, pwr_en};
               default: act = {10'd0, rng_sel};
            endcase
            checks++;
            if (act !== it.exp) begin
               errors++;
               $display("FAIL %s sel=%0d actual=%h expected=%h", it.req, it.sel, act, it.exp);
            end
         end
      end
   end

   task automatic summary();
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog actual=timeout expected=completion");
         summary();
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R1 reset state
      bus_read("R1", 8'hFD, 8'h04);
      bus_read("R1", 8'hF9, 8'h00);
      bus_read("R1", 8'hFA, 8'h00);
      bus_read("R1", 8'hFB, 8'h00);
      bus_read("R1", 8'hFC, 8'h00);
      expect_outputs("R1");
      @(negedge clk);

      // R3 direct 12-bit loads
      bus_write(8'hFD, 8'h1F);
      bus_write(8'hFA, 8'hA5);
      bus_read("R2", 8'hFA, 8'h05);
      expect_outputs("R3");
      bus_write(8'hF9, 8'h3C);
      expect_item("R3", 1, 12'h53C);
      bus_write(8'hFC, 8'h0F);
      bus_write(8'hFB, 8'hFF);
      expect_item("R3", 2, 12'hFFF);
      bus_read("R2", 8'hF9, 8'h3C);
      bus_read("R2", 8'hFB, 8'hFF);
      bus_read("R2", 8'h00, 8'h00);
      bus_read("R2", 8'hF8, 8'h00);
      bus_read("R2", 8'hFE, 8'h00);

      // R4 deferred, R5 simultaneous
      bus_write(8'hFD, 8'h1B);
      bus_write(8'hFA, 8'h02);
      bus_write(8'hF9, 8'h11);
      bus_write(8'hFC, 8'h03);
      bus_write(8'hFB, 8'h22);
      expect_item("R4", 1, 12'h53C);
      expect_item("R4", 2, 12'hFFF);
      bus_write(8'hFD, 8'h1F);
      expect_item("R5", 1, 12'h211);
      expect_item("R5", 2, 12'h322);

      // R6 sync already set: no reload
      bus_write(8'hFA, 8'h07);
      bus_write(8'hFD, 8'h1F);
      expect_item("R6", 1, 12'h211);
      bus_write(8'hF9, 8'h11);
      expect_item("R3", 1, 12'h711);

      // R7 narrow mode
      bus_write(8'hFD, 8'h9F);
      bus_write(8'hF9, 8'hC3);
      expect_item("R7", 1, 12'hC30);
      bus_write(8'hFA, 8'h0F);
      expect_item("R7", 1, 12'hC30);
      bus_write(8'hFD, 8'h9B);
      bus_write(8'hFB, 8'h44);
      expect_item("R7", 2, 12'h322);
      bus_write(8'hFD, 8'h9F);
      expect_item("R7", 2, 12'h440);
      expect_outputs("R7");

      // R8 clear forcing and recovery
      bus_write(8'hFD, 8'h97);
      expect_item("R8", 1, 12'h000);
      expect_item("R8", 2, 12'h440);
      bus_write(8'hFD, 8'h9F);
      expect_item("R8", 1, 12'hC30);

      // R9 power-down forcing and recovery
      bus_write(8'hFD, 8'h9D);
      expect_item("R9", 2, 12'h000);
      expect_item("R9", 3, 12'h001);
      bus_write(8'hFD, 8'h9F);
      expect_item("R9", 2, 12'h440);
      expect_item("R9", 3, 12'h003);

      // R10 range bits
      bus_write(8'hFD, 8'hDF);
      expect_item("R10", 4, 12'h002);
      bus_write(8'hFD, 8'hBF);
      expect_item("R10", 4, 12'h001);
      bus_read("R2", 8'hFD, 8'hBF);
      expect_outputs("R10");

      repeat (3) @(negedge clk);
      done = 1;
      summary();
   end
endmodule